// File: doc/BRIEF.md
# Exception and interrupt entry controller

This block sits beside a processor core's pipeline control and decides, each clock, whether the core enters a handler. It receives a pending exception (a valid bit plus an event code), a hardware interrupt request together with the vector and vector-valid flag from an external priority controller, the core's sleep flag, and the current status word, program counter, stack register, vector base and delay-slot flag. If an event is accepted, the whole entry sequence is written in the following clock edge. The status word, program counter and stack register are saved. The status word gets its privilege, bank and block bits set. The event code is logged. The new program counter is formed from the event class.

Exceptions always win over interrupts. While the block bit is set, exceptions are turned into a reset, except for one code that is allowed through. Interrupts wait unless the core is asleep. A branch delay slot moves the saved PC back so the branch runs again, and a trap moves it forward past the trap instruction. The acknowledge outputs tell the sources in the same cycle that their event was consumed. The sleep-clear and delay-slot-clear strobes tell the core which flags to drop.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When `exc_valid` is high, no interrupt is accepted in that cycle (`ack_irq` low) and the exception is taken (`ack_exc` high).
- R2: With status bit 28 (block) set, an exception whose code is not 0x1E0 is logged as code 0x000 and handled as reset class; code 0x1E0 is logged and handled unchanged.
- R3: With status bit 28 set and `sleep_in` low, an interrupt request is not accepted; with `sleep_in` high it is accepted. `sleep_clr` is high in every cycle in which an event is accepted.
- R4: On an accepted event, the next cycle shows `ssr_out` = the old status, `sgr_out` = `r15_in`, and `sr_out` = the old status with bits 28, 29 (bank) and 30 (privileged) set.
- R5: If `dslot_in` is high on an accepted event, the saved PC is `pc_in` - 2 and `dslot_clr` is high in that cycle.
- R6: Codes 0x000, 0x020 and 0x140 clear status bit 15 (FPU disable), set status bits 7:4 to 0xF and load PC 0xA0000000.
- R7: Codes 0x040 and 0x060 load PC `vbr_in` + 0x400.
- R8: Code 0x160 adds 2 to the saved PC after any delay-slot adjustment; it and all other codes not named in R6 or R7 load PC `vbr_in` + 0x100. The taken code appears on `expevt_out`.
- R9: `irq_mask` equals status bits 7:4. An interrupt with `irq_vec_valid` low is not taken. A taken interrupt writes `irq_vec` to `intevt_out` and loads PC `vbr_in` + 0x600.
- R10: `entry_vld` is high exactly in the cycle after an accepted event; with no accepted event all saved and PC outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_valid | input | 1 | An exception code is pending |
| exc_code | input | EVT_W | Pending exception code |
| irq_req | input | 1 | Hardware interrupt request |
| irq_vec_valid | input | 1 | Priority controller has an unmasked vector |
| irq_vec | input | EVT_W | Interrupt vector from the priority controller |
| irq_mask | output | 4 | Current interrupt mask sent to the priority controller |
| sleep_in | input | 1 | Core is in sleep |
| sleep_clr | output | 1 | Clear the sleep flag (event accepted) |
| sr_in | input | XLEN | Current status word |
| pc_in | input | XLEN | Current program counter |
| r15_in | input | XLEN | Current stack register |
| vbr_in | input | XLEN | Vector base |
| dslot_in | input | 1 | Current instruction is in a delay slot |
| dslot_clr | output | 1 | Clear the delay-slot flags |
| ack_exc | output | 1 | Exception consumed this cycle |
| ack_irq | output | 1 | Interrupt consumed this cycle |
| entry_vld | output | 1 | Entry outputs were updated at the last edge |
| sr_out | output | XLEN | New status word |
| ssr_out | output | XLEN | Saved status word |
| spc_out | output | XLEN | Saved program counter |
| sgr_out | output | XLEN | Saved stack register |
| expevt_out | output | EVT_W | Last exception code taken |
| intevt_out | output | EVT_W | Last interrupt vector taken |
| pc_out | output | XLEN | Handler entry address |

## Verification
The assertions take for granted that a source holds its request stable through a cycle and drops it after the acknowledge. They also assume `sr_in`, `pc_in` and `vbr_in` are valid whenever a request is present. They do not model what the core does with the new status, so the status input is never assumed to follow `sr_out`. The stimulus drives every input from a table row at the falling edge and holds it for one full cycle. It sets the status input explicitly for each row rather than feeding back the block's output. This keeps each row's expected result a pure function of that row's inputs.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
   // status word bit positions
   localparam int SR_FD    = 15;
   localparam int SR_BL    = 28;
   localparam int SR_RB    = 29;
   localparam int SR_MD    = 30;
   localparam int SR_IM_LO = 4;
   localparam int SR_IM_W  = 4;

   // event codes with special handling
   localparam logic [11:0] CODE_PASS_BL = 12'h1E0;
   localparam logic [11:0] CODE_TRAP    = 12'h160;
   localparam int N_RST  = 3;
   localparam int N_MISS = 2;
   localparam logic [11:0] RST_CODES  [N_RST]  = '{12'h000, 12'h020, 12'h140};
   localparam logic [11:0] MISS_CODES [N_MISS] = '{12'h040, 12'h060};

   // handler offsets from the vector base
   localparam logic [11:0] OFS_GEN  = 12'h100;
   localparam logic [11:0] OFS_MISS = 12'h400;
   localparam logic [11:0] OFS_IRQ  = 12'h600;

   typedef enum logic [1:0] {
      CLS_GENERAL = 2'd0,
      CLS_RESET   = 2'd1,
      CLS_MISS    = 2'd2,
      CLS_TRAP    = 2'd3
   } ecls_e;
endpackage

// File: rtl/exc_select.sv
module exc_select
   import exc_entry_pkg::*;
#(
   parameter int EVT_W = 12
) (
   input  logic             exc_valid,
   input  logic [EVT_W-1:0] exc_code,
   input  logic             irq_req,
   input  logic             irq_vec_valid,
   input  logic             sleep_in,
   input  logic             blocked,
   output logic             take_exc,
   output logic             take_irq,
   output logic [EVT_W-1:0] eff_code
);
   always_comb begin
      // exceptions outrank interrupts unconditionally
      take_exc = exc_valid;
      take_irq = !exc_valid && irq_req && irq_vec_valid && (!blocked || sleep_in);
      if (blocked && (exc_code != EVT_W'(CODE_PASS_BL)))
         eff_code = '0;
      else
         eff_code = exc_code;
   end
endmodule

// File: rtl/exc_classify.sv
module exc_classify
   import exc_entry_pkg::*;
#(
   parameter int EVT_W = 12
) (
   input  logic [EVT_W-1:0] code,
   output ecls_e            cls
);
   logic [N_RST-1:0]  rst_hit;
   logic [N_MISS-1:0] miss_hit;

   for (genvar i = 0; i < N_RST; i++) begin : g_rst
      assign rst_hit[i] = (code == EVT_W'(RST_CODES[i]));
   end
   for (genvar j = 0; j < N_MISS; j++) begin : g_miss
      assign miss_hit[j] = (code == EVT_W'(MISS_CODES[j]));
   end

   always_comb begin
      if (|rst_hit)
         cls = CLS_RESET;
      else if (|miss_hit)
         cls = CLS_MISS;
      else if (code == EVT_W'(CODE_TRAP))
         cls = CLS_TRAP;
      else
         cls = CLS_GENERAL;
   end
endmodule

// File: rtl/exc_target.sv
module exc_target
   import exc_entry_pkg::*;
#(
   parameter int          XLEN     = 32,
   parameter logic [31:0] RESET_PC = 32'hA000_0000
) (
   input  ecls_e           cls,
   input  logic            is_irq,
   input  logic [XLEN-1:0] sr_in,
   input  logic [XLEN-1:0] pc_in,
   input  logic [XLEN-1:0] vbr_in,
   input  logic            dslot_in,
   output logic [XLEN-1:0] new_sr,
   output logic [XLEN-1:0] new_spc,
   output logic [XLEN-1:0] new_pc
);
   localparam logic [XLEN-1:0] STEP = XLEN'(2);

   always_comb begin
      new_sr         = sr_in;
      new_sr[SR_BL]  = 1'b1;
      new_sr[SR_RB]  = 1'b1;
      new_sr[SR_MD]  = 1'b1;
      new_spc        = dslot_in ? (pc_in - STEP) : pc_in;
      new_pc         = vbr_in + XLEN'(OFS_GEN);
      if (is_irq) begin
         new_pc = vbr_in + XLEN'(OFS_IRQ);
      end else begin
         case (cls)
            CLS_RESET: begin
               new_sr[SR_FD]                 = 1'b0;
               new_sr[SR_IM_LO +: SR_IM_W]   = '1;
               new_pc                        = XLEN'(RESET_PC);
            end
            CLS_MISS:  new_pc  = vbr_in + XLEN'(OFS_MISS);
            CLS_TRAP:  new_spc = new_spc + STEP;
            default:   new_pc  = vbr_in + XLEN'(OFS_GEN);
         endcase
      end
   end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_entry_pkg::*;
#(
   parameter int          XLEN     = 32,
   parameter int          EVT_W    = 12,
   parameter logic [31:0] RESET_PC = 32'hA000_0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             exc_valid,
   input  logic [EVT_W-1:0] exc_code,
   input  logic             irq_req,
   input  logic             irq_vec_valid,
   input  logic [EVT_W-1:0] irq_vec,
   output logic [3:0]       irq_mask,
   input  logic             sleep_in,
   output logic             sleep_clr,
   input  logic [XLEN-1:0]  sr_in,
   input  logic [XLEN-1:0]  pc_in,
   input  logic [XLEN-1:0]  r15_in,
   input  logic [XLEN-1:0]  vbr_in,
   input  logic             dslot_in,
   output logic             dslot_clr,
   output logic             ack_exc,
   output logic             ack_irq,
   output logic             entry_vld,
   output logic [XLEN-1:0]  sr_out,
   output logic [XLEN-1:0]  ssr_out,
   output logic [XLEN-1:0]  spc_out,
   output logic [XLEN-1:0]  sgr_out,
   output logic [EVT_W-1:0] expevt_out,
   output logic [EVT_W-1:0] intevt_out,
   output logic [XLEN-1:0]  pc_out
);
   // elaboration checks
   if (XLEN < 32) begin : g_chk_xlen
      $error("exc_entry_ctrl: XLEN must hold the status bits up to 30");
   end
   if (EVT_W < 9) begin : g_chk_evt
      $error("exc_entry_ctrl: EVT_W too narrow for the event codes");
   end

   logic             take_exc, take_irq, take_any;
   logic [EVT_W-1:0] eff_code;
   ecls_e            cls;
   logic [XLEN-1:0]  new_sr, new_spc, new_pc;

   exc_select #(.EVT_W(EVT_W)) u_sel (
      .exc_valid(exc_valid), .exc_code(exc_code), .irq_req(irq_req),
      .irq_vec_valid(irq_vec_valid), .sleep_in(sleep_in),
      .blocked(sr_in[SR_BL]), .take_exc(take_exc), .take_irq(take_irq),
      .eff_code(eff_code)
   );

   exc_classify #(.EVT_W(EVT_W)) u_cls (.code(eff_code), .cls(cls));

   exc_target #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_tgt (
      .cls(cls), .is_irq(take_irq), .sr_in(sr_in), .pc_in(pc_in),
      .vbr_in(vbr_in), .dslot_in(dslot_in), .new_sr(new_sr),
      .new_spc(new_spc), .new_pc(new_pc)
   );

   assign take_any  = take_exc | take_irq;
   assign ack_exc   = take_exc;
   assign ack_irq   = take_irq;
   assign sleep_clr = take_any;
   assign dslot_clr = take_any & dslot_in;
   assign irq_mask  = sr_in[SR_IM_LO +: SR_IM_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         entry_vld  <= 1'b0;
         sr_out     <= '0;
         ssr_out    <= '0;
         spc_out    <= '0;
         sgr_out    <= '0;
         expevt_out <= '0;
         intevt_out <= '0;
         pc_out     <= '0;
      end else begin
         entry_vld <= take_any;
         if (take_any) begin
            sr_out  <= new_sr;
            ssr_out <= sr_in;
            spc_out <= new_spc;
            sgr_out <= r15_in;
            pc_out  <= new_pc;
         end
         if (take_exc) expevt_out <= eff_code;
         if (take_irq) intevt_out <= irq_vec;
      end
   end

   // R1: a pending exception shuts out the interrupt path
   p_exc_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> (ack_exc && !ack_irq));

   // R2: blocked exceptions other than the pass code become reset entries
   p_bl_remap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && sr_in[SR_BL] && exc_code != EVT_W'(CODE_PASS_BL))
      |=> (expevt_out == '0 && pc_out == XLEN'(RESET_PC)));

   // R3: blocked interrupt only when awake
   p_irq_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_in[SR_BL] && !sleep_in) |-> !ack_irq);

   // R4: saved state and status bits after an accepted event
   p_save_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_exc || ack_irq) |=> (ssr_out == $past(sr_in) && sgr_out == $past(r15_in)
                                && sr_out[SR_BL] && sr_out[SR_RB] && sr_out[SR_MD]));

   // R9: interrupt entry address and vector log
   p_irq_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ack_irq |=> (pc_out == $past(vbr_in) + XLEN'(OFS_IRQ) && intevt_out == $past(irq_vec)));

   // R10: nothing accepted means no pulse and held PC
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack_exc || ack_irq) |=> (!entry_vld && $stable(pc_out) && $stable(spc_out)));
endmodule

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exc_valid = 1'b0;
   logic [11:0] exc_code = '0;
   logic        irq_req = 1'b0;
   logic        irq_vec_valid = 1'b0;
   logic [11:0] irq_vec = '0;
   logic [3:0]  irq_mask;
   logic        sleep_in = 1'b0;
   logic        sleep_clr;
   logic [31:0] sr_in = '0;
   logic [31:0] pc_in = 32'h0C00_1000;
   logic [31:0] r15_in = 32'h0000_F000;
   logic [31:0] vbr_in = 32'h8C00_0000;
   logic        dslot_in = 1'b0;
   logic        dslot_clr, ack_exc, ack_irq, entry_vld;
   logic [31:0] sr_out, ssr_out, spc_out, sgr_out, pc_out;
   logic [11:0] expevt_out, intevt_out;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   exc_entry_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
      .irq_req(irq_req), .irq_vec_valid(irq_vec_valid), .irq_vec(irq_vec),
      .irq_mask(irq_mask), .sleep_in(sleep_in), .sleep_clr(sleep_clr),
      .sr_in(sr_in), .pc_in(pc_in), .r15_in(r15_in), .vbr_in(vbr_in),
      .dslot_in(dslot_in), .dslot_clr(dslot_clr), .ack_exc(ack_exc),
      .ack_irq(ack_irq), .entry_vld(entry_vld), .sr_out(sr_out),
      .ssr_out(ssr_out), .spc_out(spc_out), .sgr_out(sgr_out),
      .expevt_out(expevt_out), .intevt_out(intevt_out), .pc_out(pc_out)
   );

   typedef struct packed {
      logic        exc_v;
      logic [11:0] code;
      logic        irq;
      logic        ivv;
      logic [11:0] ivec;
      logic        slp;
      logic [31:0] sr;
      logic        ds;
      logic [1:0]  take;   // 0 none, 1 exception, 2 interrupt
      logic [31:0] epc;
      logic [31:0] espc;
      logic [31:0] esr;
      logic [11:0] eevt;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t TBL [NV] = '{
      // R7 miss read
      '{1'b1, 12'h040, 1'b0, 1'b0, 12'h000, 1'b0, 32'h0000_0000, 1'b0, 2'd1, 32'h8C00_0400, 32'h0C00_1000, 32'h7000_0000, 12'h040},
      // R7 R5 miss write in delay slot
      '{1'b1, 12'h060, 1'b0, 1'b0, 12'h000, 1'b0, 32'h0000_0000, 1'b1, 2'd1, 32'h8C00_0400, 32'h0C00_0FFE, 32'h7000_0000, 12'h060},
      // R8 trap
      '{1'b1, 12'h160, 1'b0, 1'b0, 12'h000, 1'b0, 32'h0000_0000, 1'b0, 2'd1, 32'h8C00_0100, 32'h0C00_1002, 32'h7000_0000, 12'h160},
      // R8 R5 trap in delay slot
      '{1'b1, 12'h160, 1'b0, 1'b0, 12'h000, 1'b0, 32'h0000_0000, 1'b1, 2'd1, 32'h8C00_0100, 32'h0C00_1000, 32'h7000_0000, 12'h160},
      // R8 R4 general code keeps other status bits
      '{1'b1, 12'h180, 1'b0, 1'b0, 12'h000, 1'b0, 32'h0000_8030, 1'b0, 2'd1, 32'h8C00_0100, 32'h0C00_1000, 32'h7000_8030, 12'h180},
      // R6 reset class 0x020
      '{1'b1, 12'h020, 1'b0, 1'b0, 12'h000, 1'b0, 32'h0000_8030, 1'b0, 2'd1, 32'hA000_0000, 32'h0C00_1000, 32'h7000_00F0, 12'h020},
      // R6 reset class 0x140
      '{1'b1, 12'h140, 1'b0, 1'b0, 12'h000, 1'b0, 32'h0000_8000, 1'b0, 2'd1, 32'hA000_0000, 32'h0C00_1000, 32'h7000_00F0, 12'h140},
      // R2 blocked exception becomes reset
      '{1'b1, 12'h180, 1'b0, 1'b0, 12'h000, 1'b0, 32'h1000_0000, 1'b0, 2'd1, 32'hA000_0000, 32'h0C00_1000, 32'h7000_00F0, 12'h000},
      // R2 pass code survives block
      '{1'b1, 12'h1E0, 1'b0, 1'b0, 12'h000, 1'b0, 32'h1000_0000, 1'b0, 2'd1, 32'h8C00_0100, 32'h0C00_1000, 32'h7000_0000, 12'h1E0},
      // R1 exception beats interrupt
      '{1'b1, 12'h0A0, 1'b1, 1'b1, 12'h200, 1'b0, 32'h0000_0000, 1'b0, 2'd1, 32'h8C00_0100, 32'h0C00_1000, 32'h7000_0000, 12'h0A0},
      // R9 interrupt taken
      '{1'b0, 12'h000, 1'b1, 1'b1, 12'h320, 1'b0, 32'h0000_0050, 1'b0, 2'd2, 32'h8C00_0600, 32'h0C00_1000, 32'h7000_0050, 12'h320},
      // R9 no vector: abandoned
      '{1'b0, 12'h000, 1'b1, 1'b0, 12'h000, 1'b0, 32'h0000_0000, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0, 12'h000},
      // R3 blocked, awake: ignored
      '{1'b0, 12'h000, 1'b1, 1'b1, 12'h330, 1'b0, 32'h1000_0000, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0, 12'h000},
      // R3 blocked, asleep: taken, R5 delay slot
      '{1'b0, 12'h000, 1'b1, 1'b1, 12'h3E0, 1'b1, 32'h1000_0000, 1'b1, 2'd2, 32'h8C00_0600, 32'h0C00_0FFE, 32'h7000_0000, 12'h3E0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      exc_valid     = v.exc_v;
      exc_code      = v.code;
      irq_req       = v.irq;
      irq_vec_valid = v.ivv;
      irq_vec       = v.ivec;
      sleep_in      = v.slp;
      sr_in         = v.sr;
      dslot_in      = v.ds;
   endtask

   task automatic idle();
      exc_valid = 1'b0; irq_req = 1'b0; irq_vec_valid = 1'b0;
      sleep_in = 1'b0; dslot_in = 1'b0; sr_in = '0;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] hpc, hspc, hsr;
      repeat (3) @(negedge clk);
      // reset state, R10
      chk("R10 reset entry_vld", {31'b0, entry_vld}, 32'd0);
      chk("R10 reset pc_out", pc_out, 32'd0);
      chk("R10 reset sr_out", sr_out, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      hpc = pc_out; hspc = spc_out; hsr = sr_out;

      for (int i = 0; i < NV; i++) begin
         drive(TBL[i]);
         #2;
         chk($sformatf("R1/R3 ack_exc row %0d", i), {31'b0, ack_exc}, {31'b0, TBL[i].take == 2'd1});
         chk($sformatf("R1/R3/R9 ack_irq row %0d", i), {31'b0, ack_irq}, {31'b0, TBL[i].take == 2'd2});
         chk($sformatf("R3 sleep_clr row %0d", i), {31'b0, sleep_clr}, {31'b0, TBL[i].take != 2'd0});
         chk($sformatf("R5 dslot_clr row %0d", i), {31'b0, dslot_clr},
             {31'b0, (TBL[i].take != 2'd0) && TBL[i].ds});
         chk($sformatf("R9 irq_mask row %0d", i), {28'b0, irq_mask}, {28'b0, TBL[i].sr[7:4]});
         @(negedge clk);
         chk($sformatf("R10 entry_vld row %0d", i), {31'b0, entry_vld}, {31'b0, TBL[i].take != 2'd0});
         if (TBL[i].take != 2'd0) begin
            chk($sformatf("R6/R7/R8/R9 pc row %0d", i), pc_out, TBL[i].epc);
            chk($sformatf("R4/R5/R8 spc row %0d", i), spc_out, TBL[i].espc);
            chk($sformatf("R4/R6 sr row %0d", i), sr_out, TBL[i].esr);
            chk($sformatf("R4 ssr row %0d", i), ssr_out, TBL[i].sr);
            chk($sformatf("R4 sgr row %0d", i), sgr_out, 32'h0000_F000);
            if (TBL[i].take == 2'd1)
               chk($sformatf("R2/R8 expevt row %0d", i), {20'b0, expevt_out}, {20'b0, TBL[i].eevt});
            else
               chk($sformatf("R9 intevt row %0d", i), {20'b0, intevt_out}, {20'b0, TBL[i].eevt});
            hpc = TBL[i].epc; hspc = TBL[i].espc; hsr = TBL[i].esr;
         end else begin
            chk($sformatf("R3/R9/R10 held pc row %0d", i), pc_out, hpc);
            chk($sformatf("R10 held spc row %0d", i), spc_out, hspc);
            chk($sformatf("R10 held sr row %0d", i), sr_out, hsr);
         end
      end

      // R10: pulse lasts one cycle once requests go away
      idle();
      @(negedge clk);
      chk("R10 pulse ends", {31'b0, entry_vld}, 32'd0);
      chk("R10 pc held after idle", pc_out, hpc);

      // R1 R2: blocked, asleep, both pending -> remapped exception wins
      exc_valid = 1'b1; exc_code = 12'h0A0; irq_req = 1'b1; irq_vec_valid = 1'b1;
      irq_vec = 12'h3C0; sleep_in = 1'b1; sr_in = 32'h1000_0000;
      #2;
      chk("R1 ack_irq suppressed", {31'b0, ack_irq}, 32'd0);
      chk("R1 ack_exc", {31'b0, ack_exc}, 32'd1);
      @(negedge clk);
      chk("R2 expevt remapped", {20'b0, expevt_out}, 32'h000);
      chk("R2/R6 pc reset", pc_out, 32'hA000_0000);
      chk("R9 intevt untouched", {20'b0, intevt_out}, 32'h3E0);
      idle();
      @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule